// File: doc/BRIEF.md
# Unaligned Byte-Addressed Load/Store Unit

This unit sits between a 32-bit scalar core and a 4 KB byte-addressed data store. Each request carries a base value, a signed immediate, an operation code and, for stores, the data to write. The effective address is the sum of base and the sign-extended immediate, kept to its low 12 bits. Word and halfword accesses may begin at any byte. The unit splits an access over word rows and, past the top of memory, over the wrap to address zero. It never faults.

Storage is four byte-wide banks. Bank `b` holds the bytes whose address has low bits equal to `b`. Any access of up to four consecutive bytes therefore touches each bank at most once, and every bank gets its own row address and enable in the same cycle. Stores write in that cycle. Loads read synchronously, and the result is assembled in the next cycle, big-endian and sign- or zero-extended.

A two-state machine drives the response. `ST_IDLE` means no result is due. `ST_RESP` means a load result is on the outputs this cycle. The transitions are:
- `T_ISSUE`: from `ST_IDLE` to `ST_RESP` when a load is requested.
- `T_STREAM`: from `ST_RESP` back to `ST_RESP` when another load is requested.
- `T_DRAIN`: from `ST_RESP` to `ST_IDLE` when no load is requested.
- `T_WAIT`: from `ST_IDLE` back to `ST_IDLE` when no load is requested.

Top module: `lsu_top`

## Requirements
- R1: The effective address is (base + sign-extended offset) mod 4096. All higher sum bits have no effect.
- R2: A word load (op 0) at any byte address A returns bytes A, A+1, A+2 and A+3, with byte A in bits 31:24.
- R3: A halfword load returns bytes A and A+1, with byte A in bits 15:8. The signed form (op 1) copies bit 15 into bits 31:16. The unsigned form (op 2) clears bits 31:16.
- R4: A byte load returns byte A in bits 7:0. The signed form (op 3) copies bit 7 into bits 31:8. The unsigned form (op 4) clears bits 31:8.
- R5: A word store (op 5) at any byte address A writes store_data bits 31:24, 23:16, 15:8 and 7:0 to bytes A through A+3, in that order. It changes no other byte.
- R6: A halfword store (op 6) writes store_data bits 15:8 to byte A and bits 7:0 to byte A+1. A byte store (op 7) writes bits 7:0 to byte A. Neither changes any other byte, and both ignore the unused high bits of store_data.
- R7: An access that runs past byte 0xFFF continues at byte 0x000 for its remaining bytes, for loads and for stores.
- R8: A load result appears with rsp_valid high exactly one cycle after the request. A store produces no response. rsp_data is zero whenever rsp_valid is low.
- R9: While reset is asserted, rsp_valid is low and rsp_data is zero.
- R10: Loads on consecutive cycles each produce their own result one cycle later, with rsp_valid staying high throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | Operation: 0 LW, 1 LH, 2 LHU, 3 LB, 4 LBU, 5 SW, 6 SH, 7 SB |
| req_base | input | 32 | Base address value |
| req_offset | input | 16 | Signed immediate offset |
| req_wdata | input | 32 | Store data, right-aligned for halfword and byte stores |
| rsp_valid | output | 1 | Load result valid |
| rsp_data | output | 32 | Extended load result |

## Verification
Store effects are due at the clock edge that samples the request. The bench therefore checks them through a word load issued in the next cycle. Load results are due one edge after the request. Inputs are driven just after a falling edge and outputs are sampled at the following falling edge, so every check falls exactly in the cycle its result is due. Loads are issued back to back for the whole sweep, so the single-cycle latency is checked under continuous traffic as well as after stores. The expected bytes come from a byte-array model in the bench, with modulo-4096 arithmetic.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
    localparam int NBYTES = 4;
    localparam int WORD_W = 8 * NBYTES;

    typedef enum logic [2:0] {
        OP_LW  = 3'd0,
        OP_LH  = 3'd1,
        OP_LHU = 3'd2,
        OP_LB  = 3'd3,
        OP_LBU = 3'd4,
        OP_SW  = 3'd5,
        OP_SH  = 3'd6,
        OP_SB  = 3'd7
    } lsu_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } rsp_state_e;

    function automatic logic op_is_load(input logic [2:0] op);
        return op <= 3'(OP_LBU);
    endfunction

    function automatic logic [2:0] op_size(input logic [2:0] op);
        unique case (op)
            3'(OP_LW), 3'(OP_SW):                return 3'd4;
            3'(OP_LH), 3'(OP_LHU), 3'(OP_SH):    return 3'd2;
            default:                             return 3'd1;
        endcase
    endfunction
endpackage

// File: rtl/lsu_addr.sv
module lsu_addr
    import lsu_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int OFF_W  = 16,
    localparam int ROW_W = ADDR_W - 2
) (
    input  logic [WORD_W-1:0] base,
    input  logic [OFF_W-1:0]  offset,
    input  logic [2:0]        op,
    input  logic [WORD_W-1:0] wdata,
    output logic [1:0]        lane,
    output logic [ROW_W-1:0]  bank_row [NBYTES],
    output logic              bank_hit [NBYTES],
    output logic [7:0]        bank_wdata [NBYTES]
);
    logic [WORD_W-1:0] ea_full;
    logic [ADDR_W-1:0] ea;
    logic [2:0]        size;
    logic              unused_ea;

    assign ea_full   = base + WORD_W'(signed'(offset));
    assign ea        = ea_full[ADDR_W-1:0];
    assign unused_ea = ^ea_full[WORD_W-1:ADDR_W];
    assign lane      = ea[1:0];
    assign size      = op_size(op);

    for (genvar b = 0; b < NBYTES; b++) begin : g_bank_map
        logic [1:0]        k;
        logic [ADDR_W-1:0] byte_addr;
        logic [2:0]        src;

        assign k             = 2'(b) - ea[1:0];
        assign byte_addr     = ea + ADDR_W'(k);
        assign bank_row[b]   = byte_addr[ADDR_W-1:2];
        assign bank_hit[b]   = {1'b0, k} < size;
        assign src           = size - 3'd1 - {1'b0, k};
        assign bank_wdata[b] = wdata[{src[1:0], 3'b000} +: 8];
    end
endmodule

// File: rtl/lsu_bank.sv
module lsu_bank #(
    parameter int ROW_W = 10,
    localparam int DEPTH = 1 << ROW_W
) (
    input  logic             clk,
    input  logic             rd_en,
    input  logic             wr_en,
    input  logic [ROW_W-1:0] row,
    input  logic [7:0]       wdata,
    output logic [7:0]       rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[row] <= wdata;
        end
        if (rd_en) begin
            rdata <= mem[row];
        end
    end
endmodule

// File: rtl/lsu_steer.sv
module lsu_steer
    import lsu_pkg::*;
(
    input  logic [7:0]        bank_rdata [NBYTES],
    input  logic [1:0]        lane,
    input  logic [2:0]        op,
    output logic [WORD_W-1:0] data
);
    logic [7:0] seq [NBYTES];

    for (genvar k = 0; k < NBYTES; k++) begin : g_gather
        assign seq[k] = bank_rdata[2'(lane + 2'(k))];
    end

    always_comb begin
        unique case (op)
            3'(OP_LW):  data = {seq[0], seq[1], seq[2], seq[3]};
            3'(OP_LH):  data = {{16{seq[0][7]}}, seq[0], seq[1]};
            3'(OP_LHU): data = {16'h0000, seq[0], seq[1]};
            3'(OP_LB):  data = {{24{seq[0][7]}}, seq[0]};
            3'(OP_LBU): data = {24'h000000, seq[0]};
            default:    data = '0;
        endcase
    end
endmodule

// File: rtl/lsu_top.sv
module lsu_top
    import lsu_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int OFF_W  = 16,
    localparam int ROW_W = ADDR_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic [31:0]       req_base,
    input  logic [OFF_W-1:0]  req_offset,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_data
);
    rsp_state_e        state, state_nx;
    logic              load_req, store_req;
    logic [1:0]        lane;
    logic [1:0]        resp_lane;
    logic [2:0]        resp_op;
    logic [ROW_W-1:0]  bank_row   [NBYTES];
    logic              bank_hit   [NBYTES];
    logic [7:0]        bank_wdata [NBYTES];
    logic [7:0]        bank_rdata [NBYTES];
    logic [WORD_W-1:0] steer_data;

    assign load_req  = req_valid && op_is_load(req_op);
    assign store_req = req_valid && !op_is_load(req_op);

    lsu_addr #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) i_addr (
        .base       (req_base),
        .offset     (req_offset),
        .op         (req_op),
        .wdata      (req_wdata),
        .lane       (lane),
        .bank_row   (bank_row),
        .bank_hit   (bank_hit),
        .bank_wdata (bank_wdata)
    );

    for (genvar b = 0; b < NBYTES; b++) begin : g_banks
        lsu_bank #(.ROW_W(ROW_W)) i_bank (
            .clk   (clk),
            .rd_en (load_req && bank_hit[b]),
            .wr_en (store_req && bank_hit[b]),
            .row   (bank_row[b]),
            .wdata (bank_wdata[b]),
            .rdata (bank_rdata[b])
        );
    end

    lsu_steer i_steer (
        .bank_rdata (bank_rdata),
        .lane       (resp_lane),
        .op         (resp_op),
        .data       (steer_data)
    );

    // Next state: T_ISSUE / T_STREAM on a load, T_DRAIN / T_WAIT otherwise.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: state_nx = load_req ? ST_RESP : ST_IDLE;
            ST_RESP: state_nx = load_req ? ST_RESP : ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            resp_lane <= '0;
            resp_op   <= '0;
        end else begin
            state <= state_nx;
            if (load_req) begin
                resp_lane <= lane;
                resp_op   <= req_op;
            end
        end
    end

    always_comb begin
        unique case (state)
            ST_RESP: begin
                rsp_valid = 1'b1;
                rsp_data  = steer_data;
            end
            default: begin
                rsp_valid = 1'b0;
                rsp_data  = '0;
            end
        endcase
    end
endmodule

// File: rtl/lsu_checker.sv
module lsu_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [2:0]  req_op,
    input logic        rsp_valid,
    input logic [31:0] rsp_data
);
    logic is_load;
    assign is_load = req_valid && (req_op <= 3'd4);

    p_resp_after_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        is_load |=> rsp_valid);

    p_no_resp_otherwise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !is_load |=> !rsp_valid);

    p_quiet_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> rsp_data == 32'h0);

    p_half_sext_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 3'd1) |=> rsp_data[31:15] == {17{rsp_data[15]}});

    p_half_zext_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 3'd2) |=> rsp_data[31:16] == 16'h0);

    p_byte_sext_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 3'd3) |=> rsp_data[31:7] == {25{rsp_data[7]}});

    p_byte_zext_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 3'd4) |=> rsp_data[31:8] == 24'h0);

    always_comb begin
        if (!rst_n) begin
            a_reset_quiet_r9: assert (!rsp_valid || $isunknown(rsp_valid) || rsp_data == 32'h0);
        end
    end
endmodule

bind lsu_top lsu_checker i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_op    (req_op),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data)
);

// File: tb/test_lsu_top.sv
module test_lsu_top;
    localparam int MSZ = 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_op = '0;
    logic [31:0] req_base = '0;
    logic [15:0] req_offset = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_data;

    int checks = 0;
    int errors = 0;
    logic [7:0] model [MSZ];

    always #4 clk = ~clk;

    lsu_top i_lsu_top (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_op     (req_op),
        .req_base   (req_base),
        .req_offset (req_offset),
        .req_wdata  (req_wdata),
        .rsp_valid  (rsp_valid),
        .rsp_data   (rsp_data)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic int size_of(input int op);
        if (op == 0 || op == 5) return 4;
        if (op == 1 || op == 2 || op == 6) return 2;
        return 1;
    endfunction

    function automatic logic [31:0] model_load(input int op, input int a);
        logic [7:0] b0, b1, b2, b3;
        b0 = model[a % MSZ];
        b1 = model[(a + 1) % MSZ];
        b2 = model[(a + 2) % MSZ];
        b3 = model[(a + 3) % MSZ];
        case (op)
            0: return {b0, b1, b2, b3};
            1: return {{16{b0[7]}}, b0, b1};
            2: return {16'h0, b0, b1};
            3: return {{24{b0[7]}}, b0};
            default: return {24'h0, b0};
        endcase
    endfunction

    // base chosen so that base + sext(off) has low 12 bits equal to a
    function automatic logic [31:0] base_for(input int a, input logic [15:0] off);
        return 32'h1234_5000 + 32'(a) - 32'(signed'(off));
    endfunction

    task automatic do_load(input int op, input int a, input logic [15:0] off, input string tag);
        req_valid  = 1'b1;
        req_op     = 3'(op);
        req_offset = off;
        req_base   = base_for(a, off);
        @(negedge clk);
        check({tag, " valid"}, {31'h0, rsp_valid}, 32'h1);
        check(tag, rsp_data, model_load(op, a));
        req_valid = 1'b0;
    endtask

    task automatic do_store(input int op, input int a, input logic [15:0] off, input logic [31:0] d);
        int sz;
        req_valid  = 1'b1;
        req_op     = 3'(op);
        req_offset = off;
        req_base   = base_for(a, off);
        req_wdata  = d;
        @(negedge clk);
        check("R8 store no valid", {31'h0, rsp_valid}, 32'h0);
        check("R8 store data zero", rsp_data, 32'h0);
        req_valid = 1'b0;
        sz = size_of(op);
        for (int k = 0; k < sz; k++) begin
            model[(a + k) % MSZ] = d[8*(sz-1-k) +: 8];
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        check("R9 reset valid", {31'h0, rsp_valid}, 32'h0);
        check("R9 reset data", rsp_data, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 idle after reset", {31'h0, rsp_valid}, 32'h0);

        // fill every byte with byte stores, high data bits set as noise (R6)
        for (int a = 0; a < MSZ; a++) begin
            do_store(7, a, 16'(-(a % 300)), 32'hDEAD_BE00 | 32'((a * 37 + (a >> 5)) & 8'hFF));
        end

        // R1: same address reached through different base / offset splits
        req_valid = 1'b1; req_op = 3'd0; req_base = 32'hFFFF_F123; req_offset = 16'h0;
        @(negedge clk);
        check("R1 high base bits", rsp_data, model_load(0, 12'h123));
        req_base = 32'h0000_0100; req_offset = 16'h0023;
        @(negedge clk);
        check("R1 positive offset", rsp_data, model_load(0, 12'h123));
        req_base = 32'h8000_0200; req_offset = 16'hFF23;
        @(negedge clk);
        check("R1 negative offset", rsp_data, model_load(0, 12'h123));
        req_base = 32'h0000_0005; req_offset = 16'hFFF0;
        @(negedge clk);
        check("R1 negative wrap", rsp_data, model_load(0, MSZ - 11));
        req_valid = 1'b0;

        // full load sweep, back to back (R2 R3 R4 R7 R10)
        for (int a = 0; a < MSZ; a++) begin
            for (int op = 0; op < 5; op++) begin
                string tag;
                if (a + size_of(op) > MSZ) tag = "R7 load wrap";
                else if (op == 0) tag = "R2 word load";
                else if (op < 3) tag = "R3 half load";
                else tag = "R4 byte load";
                if (a % 512 == 0 && op == 0) tag = {tag, " R10"};
                do_load(op, a, 16'((a % 7) * 37 - 100), tag);
            end
        end

        // stores at many alignments, including across the top (R5 R6 R7)
        for (int i = 0; i < 80; i++) begin
            int a;
            int op;
            string tag;
            a  = (i < 16) ? ((MSZ - 8 + i) % MSZ) : ((i * 67 + i / 3) % MSZ);
            op = 5 + (i % 3);
            do_store(op, a, 16'(i * 5 - 40), 32'h8100_0000 + 32'(i * 32'h0101_0307));
            if (a + size_of(op) > MSZ) tag = "R7 store wrap";
            else if (op == 5) tag = "R5 word store";
            else tag = "R6 half/byte store";
            do_load(0, (a + MSZ - 4) % MSZ, 16'h0004, tag);
            do_load(0, a, 16'hFFFE, tag);
            do_load(0, (a + 4) % MSZ, 16'h0000, tag);
        end

        @(negedge clk);
        check("R8 drain to idle", {31'h0, rsp_valid}, 32'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule